// File: doc/BRIEF.md
# PWM Channel Configuration Register Bank

This block is the software-facing register bank that sits in front of a group of PWM channel generators. A plain register bus supplies a 32-bit byte address, 32-bit write data and a write strobe. Read data is returned combinationally for the address currently on the bus. The bank holds a control word with one enable bit per channel, plus two 32-bit configuration words per channel: an active word and a period word. It drives these to the generators as flat vectors.

The control word has three alias addresses next to it that set, clear or toggle selected enable bits in a single write. Software can therefore start or stop one channel without first reading the control word. The period word is the last word of a channel's update sequence. Writing it raises a one-cycle commit strobe for that channel, so the generator can latch a consistent pair of words. The number of channels is a parameter.

Top module: `pwm_cfg_regs`

## Requirements
- R1: While rst_ni is low, every enable bit, every active word, every period word, every commit strobe and the read data of every mapped address are zero.
- R2: A write to byte address 0x00 replaces the enable bits with the low NUM_CH bits of the write data. Bit n of the control word enables channel n and appears on ch_en_o[n] after the write edge.
- R3: A write to address 0x04 sets the enable bits whose write-data bit is 1 and leaves the other enable bits as they were.
- R4: A write to address 0x08 clears the enable bits whose write-data bit is 1 and leaves the other enable bits as they were.
- R5: A write to address 0x0C inverts the enable bits whose write-data bit is 1 and leaves the other enable bits as they were.
- R6: Channel n's active word is at address 0x10 + 0x20*n. A write stores all 32 bits, drives them on ch_active_o[32n+31:32n] and reads them back.
- R7: Channel n's period word is at address 0x20 + 0x20*n. A write stores all 32 bits, drives them on ch_period_o[32n+31:32n] and reads them back. The word changes only on such a write or on reset.
- R8: A write to channel n's period word sets commit_o[n] high for exactly the one cycle after the write edge, with no other commit bit set. commit_o is zero in every cycle that does not follow a period write.
- R9: Reads from 0x04, 0x08 and 0x0C return the control word, exactly as a read from 0x00 does.
- R10: Reads return zero from every address that is not one of the word-aligned addresses above. This includes misaligned addresses, the gaps inside a channel's stride, and the addresses of channels at or above NUM_CH.
- R11: Control bits at positions NUM_CH and above read as zero, and writing ones to them has no effect.
- R12: A write to an unmapped address changes no enable bit, no configuration word and no commit strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, one write per high cycle |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| ch_en_o | output | NUM_CH | Per-channel enable bits |
| ch_active_o | output | 32*NUM_CH | Active words, channel n in bits 32n+31:32n |
| ch_period_o | output | 32*NUM_CH | Period words, channel n in bits 32n+31:32n |
| commit_o | output | NUM_CH | One-cycle per-channel commit strobes |

## Verification
The bench builds the bank with NUM_CH = 3 rather than the default of 8. With a channel count that is not a power of two and well below 32, writes of all ones to the control word must leave bits 3 to 31 clear. The addresses where a fourth channel's active and period words would sit, 0x70 and 0x80, become unmapped locations that reads and writes can probe. Three channels are still enough to show that back-to-back period writes produce a distinct one-hot commit on consecutive cycles.

// File: rtl/pwm_regs_pkg.sv
package pwm_regs_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [31:0] ACT_BASE  = 32'h10;
  localparam logic [31:0] PER_BASE  = 32'h20;
  localparam logic [31:0] CH_STRIDE = 32'h20;

  // addr[3:2] inside the control window selects the update operation
  typedef enum logic [1:0] {
    CTRL_WR  = 2'd0,
    CTRL_SET = 2'd1,
    CTRL_CLR = 2'd2,
    CTRL_TOG = 2'd3
  } ctrl_op_e;
endpackage

// File: rtl/pwm_addr_dec.sv
module pwm_addr_dec
  import pwm_regs_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic [31:0]       addr_i,
  output logic              ctrl_hit_o,
  output ctrl_op_e          ctrl_op_o,
  output logic [NUM_CH-1:0] act_hit_o,
  output logic [NUM_CH-1:0] per_hit_o
);
  assign ctrl_hit_o = (addr_i[31:4] == 28'd0) && (addr_i[1:0] == 2'b00);
  assign ctrl_op_o  = ctrl_op_e'(addr_i[3:2]);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [31:0] ACT_ADDR = ACT_BASE + CH_STRIDE * 32'(c);
    localparam logic [31:0] PER_ADDR = PER_BASE + CH_STRIDE * 32'(c);
    assign act_hit_o[c] = (addr_i == ACT_ADDR);
    assign per_hit_o[c] = (addr_i == PER_ADDR);
  end
endmodule

// File: rtl/pwm_ctrl_reg.sv
module pwm_ctrl_reg
  import pwm_regs_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  ctrl_op_e          op_i,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] en_o
);
  logic [NUM_CH-1:0] en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (wr_i) begin
      unique case (op_i)
        CTRL_WR:  en_d = wdata_i;
        CTRL_SET: en_d = en_q | wdata_i;
        CTRL_CLR: en_d = en_q & ~wdata_i;
        CTRL_TOG: en_d = en_q ^ wdata_i;
        default:  en_d = en_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_d;
  end

  assign en_o = en_q;

  assert_direct_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && op_i == CTRL_WR) |=> en_o == $past(wdata_i));
  assert_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && op_i == CTRL_SET) |=> en_o == ($past(en_o) | $past(wdata_i)));
  assert_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && op_i == CTRL_CLR) |=> en_o == ($past(en_o) & ~$past(wdata_i)));
  assert_tog_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && op_i == CTRL_TOG) |=> en_o == ($past(en_o) ^ $past(wdata_i)));
  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(en_o));
endmodule

// File: rtl/pwm_ch_regs.sv
module pwm_ch_regs
  import pwm_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              act_hit_i,
  input  logic              per_hit_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] active_o,
  output logic [WORD_W-1:0] period_o,
  output logic              commit_o
);
  logic [WORD_W-1:0] act_q, per_q;
  logic              commit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= '0;
      per_q    <= '0;
      commit_q <= 1'b0;
    end else begin
      if (we_i && act_hit_i) act_q <= wdata_i;
      if (we_i && per_hit_i) per_q <= wdata_i;
      commit_q <= we_i && per_hit_i;
    end
  end

  assign active_o = act_q;
  assign period_o = per_q;
  assign commit_o = commit_q;

  assert_period_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && per_hit_i) |=> $stable(period_o));
  assert_commit_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && per_hit_i) |=> commit_o && period_o == $past(wdata_i));
  assert_active_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && act_hit_i) |=> $stable(active_o));
endmodule

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_regs_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [31:0]              addr_i,
  input  logic [31:0]              wdata_i,
  input  logic                     we_i,
  output logic [31:0]              rdata_o,
  output logic [NUM_CH-1:0]        ch_en_o,
  output logic [WORD_W*NUM_CH-1:0] ch_active_o,
  output logic [WORD_W*NUM_CH-1:0] ch_period_o,
  output logic [NUM_CH-1:0]        commit_o
);
  localparam logic [31:0] MAP_END = ACT_BASE + CH_STRIDE * 32'(NUM_CH);

  logic              ctrl_hit;
  ctrl_op_e          ctrl_op;
  logic [NUM_CH-1:0] act_hit, per_hit;

  pwm_addr_dec #(.NUM_CH(NUM_CH)) u_dec (
    .addr_i     (addr_i),
    .ctrl_hit_o (ctrl_hit),
    .ctrl_op_o  (ctrl_op),
    .act_hit_o  (act_hit),
    .per_hit_o  (per_hit)
  );

  pwm_ctrl_reg #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (we_i && ctrl_hit),
    .op_i    (ctrl_op),
    .wdata_i (wdata_i[NUM_CH-1:0]),
    .en_o    (ch_en_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_ch_regs u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (we_i),
      .act_hit_i (act_hit[c]),
      .per_hit_i (per_hit[c]),
      .wdata_i   (wdata_i),
      .active_o  (ch_active_o[c*WORD_W +: WORD_W]),
      .period_o  (ch_period_o[c*WORD_W +: WORD_W]),
      .commit_o  (commit_o[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (ctrl_hit) rdata_o[NUM_CH-1:0] = ch_en_o;
    for (int c = 0; c < NUM_CH; c++) begin
      if (act_hit[c]) rdata_o = ch_active_o[c*WORD_W +: WORD_W];
      if (per_hit[c]) rdata_o = ch_period_o[c*WORD_W +: WORD_W];
    end
  end

  assert_commit_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(commit_o));
  assert_commit_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> commit_o == '0);
  assert_unmapped_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= MAP_END + 32'h10) |-> rdata_o == '0);
  assert_alias_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[31:4] == 28'd0 && addr_i[1:0] == 2'b00) |-> rdata_o == 32'(ch_en_o));

  if (NUM_CH < 32) begin : g_upper
    assert_upper_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_i == 32'h0) |-> rdata_o[31:NUM_CH] == '0);
  end
endmodule

// File: tb/pwm_cfg_regs_tb_top.sv
`timescale 1ns/1ps
module pwm_cfg_regs_tb_top;
  localparam int N = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [31:0]   addr_i = '0, wdata_i = '0;
  logic          we_i = 1'b0;
  logic [31:0]   rdata_o;
  logic [N-1:0]  ch_en_o, commit_o;
  logic [32*N-1:0] ch_active_o, ch_period_o;

  always #4 clk_i = ~clk_i;

  pwm_cfg_regs #(.NUM_CH(N)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .rdata_o(rdata_o), .ch_en_o(ch_en_o),
    .ch_active_o(ch_active_o), .ch_period_o(ch_period_o), .commit_o(commit_o)
  );

  typedef struct {
    int          sel;   // 0 rdata 1 enable 2 commit 3 period 4 active
    int          aux;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [N-1:0] m_en;
  logic [31:0]  m_act[N], m_per[N];

  function automatic logic [31:0] model_rd(logic [31:0] a);
    if (a < 32'h10 && a[1:0] == 2'b00) return 32'(m_en);
    for (int c = 0; c < N; c++) begin
      if (a == 32'h10 + 32'h20 * c) return m_act[c];
      if (a == 32'h20 + 32'h20 * c) return m_per[c];
    end
    return '0;
  endfunction

  function automatic void model_clear();
    m_en = '0;
    for (int c = 0; c < N; c++) begin m_act[c] = '0; m_per[c] = '0; end
  endfunction

  function automatic void push(int sel, int aux, logic [31:0] exp, string req);
    item_t it;
    it.sel = sel; it.aux = aux; it.exp = exp; it.req = req;
    q.push_back(it);
  endfunction

  task automatic op(bit we, logic [31:0] a, logic [31:0] d, string req);
    logic [N-1:0] cm;
    @(negedge clk_i);
    we_i = we; addr_i = a; wdata_i = d;
    cm = '0;
    if (!we) push(0, 0, model_rd(a), req);
    else begin
      if (a < 32'h10 && a[1:0] == 2'b00) begin
        case (a[3:2])
          2'd0: m_en = d[N-1:0];
          2'd1: m_en = m_en | d[N-1:0];
          2'd2: m_en = m_en & ~d[N-1:0];
          default: m_en = m_en ^ d[N-1:0];
        endcase
      end
      for (int c = 0; c < N; c++) begin
        if (a == 32'h10 + 32'h20 * c) m_act[c] = d;
        if (a == 32'h20 + 32'h20 * c) begin m_per[c] = d; cm[c] = 1'b1; end
      end
    end
    push(1, 0, 32'(m_en), req);
    push(2, 0, 32'(cm), req);
    for (int c = 0; c < N; c++) begin
      push(3, c, m_per[c], req);
      push(4, c, m_act[c], req);
    end
  endtask

  // monitor: compare everything queued for this edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.sel)
          0: act = rdata_o;
          1: act = 32'(ch_en_o);
          2: act = 32'(commit_o);
          3: act = ch_period_o[it.aux*32 +: 32];
          default: act = ch_active_o[it.aux*32 +: 32];
        endcase
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: sel=%0d ch=%0d actual=%h expected=%h",
                   it.req, it.sel, it.aux, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_clear();
    // R1: outputs during reset
    op(0, 32'h0, 0, "R1");
    op(0, 32'h20, 0, "R1");
    op(0, 32'h50, 0, "R1");
    @(negedge clk_i); rst_ni = 1'b1;

    // R11: upper bits masked, R2: direct write
    op(1, 32'h0, 32'hFFFF_FFFF, "R11");
    op(0, 32'h0, 0, "R11");
    op(1, 32'h0, 32'h0000_0005, "R2");
    op(0, 32'h0, 0, "R2");
    // R3 set
    op(1, 32'h4, 32'h0000_0002, "R3");
    op(1, 32'h4, 32'h0000_0000, "R3");
    op(1, 32'h0, 32'h0, "R2");
    op(1, 32'h4, 32'hFFFF_FFF9, "R3");
    // R4 clear
    op(1, 32'h8, 32'h0000_0005, "R4");
    op(1, 32'h4, 32'h7, "R3");
    op(1, 32'h8, 32'h0000_0002, "R4");
    // R5 toggle
    op(1, 32'hC, 32'h0000_0003, "R5");
    op(1, 32'hC, 32'hFFFF_FFFF, "R5");
    // R9 alias reads
    op(0, 32'h4, 0, "R9");
    op(0, 32'h8, 0, "R9");
    op(0, 32'hC, 0, "R9");
    // R6 active words
    op(1, 32'h10, 32'hA0A0_0001, "R6");
    op(1, 32'h30, 32'hA1A1_0002, "R6");
    op(1, 32'h50, 32'hA2A2_0003, "R6");
    op(0, 32'h10, 0, "R6");
    op(0, 32'h30, 0, "R6");
    op(0, 32'h50, 0, "R6");
    // R7 / R8 period words and back-to-back commits
    op(1, 32'h20, 32'h0000_1000, "R8");
    op(1, 32'h40, 32'h0000_2000, "R8");
    op(1, 32'h60, 32'hFFFF_FFFF, "R8");
    op(0, 32'h20, 0, "R7");
    op(0, 32'h40, 0, "R7");
    op(0, 32'h60, 0, "R7");
    op(1, 32'h10, 32'h1234_5678, "R8");
    // R10 unmapped reads
    op(0, 32'h14, 0, "R10");
    op(0, 32'h22, 0, "R10");
    op(0, 32'h2C, 0, "R10");
    op(0, 32'h70, 0, "R10");
    op(0, 32'h80, 0, "R10");
    op(0, 32'h1000_0000, 0, "R10");
    // R12 writes to unmapped addresses
    op(1, 32'h70, 32'hDEAD_BEEF, "R12");
    op(1, 32'h80, 32'hDEAD_BEEF, "R12");
    op(1, 32'h24, 32'hDEAD_BEEF, "R12");
    op(1, 32'h2, 32'hFFFF_FFFF, "R12");
    op(1, 32'h1000_0020, 32'hDEAD_BEEF, "R12");
    op(1, 32'h1000_0000, 32'h0, "R12");
    op(0, 32'h0, 0, "R12");
    op(0, 32'h20, 0, "R12");
    // R1 reset again after traffic
    @(negedge clk_i); rst_ni = 1'b0; model_clear();
    op(0, 32'h0, 0, "R1");
    op(0, 32'h30, 0, "R1");
    @(negedge clk_i); rst_ni = 1'b1;
    op(0, 32'h40, 0, "R1");
    repeat (3) @(negedge clk_i);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule